// File: doc/BRIEF.md
# Reset and System Configuration Controller

This block is a small register bank that sits on one page of a 16-bit paged I/O bus. It conditions the hardware reset input, generates a single-cycle soft-reset pulse for the core and peripherals, and holds two system configuration words. One is a pending word that software stages. The other is the active word that drives the chip. The pending word becomes active only when a software reset fires.

The block also holds the clock-control word, which starts in bypass, and a 10-bit lock-count value. It reports a PLL lock flag, modelled as a countdown. Whenever software writes a new multiplier value, the countdown restarts from the lock-count value. A software reset leaves the clock-control word, the lock-count value and the lock countdown untouched. The boot-mode field of both configuration words is captured from the boot-mode pins while hardware reset is in effect.

Register offsets from the base address are: 0 clock control, 1 lock count, 2 soft-reset trigger, 3 pending configuration, 4 active configuration. In the clock-control word, bits 3:0 form the multiplier field and bit 4 selects bypass. In both configuration words, bits 2:0 form the boot-mode field.

Top module: `rstcfg_ctrl`

## Requirements
- R1: hw_rst_i passes through a two-flop synchronizer, and the block stays in internal reset until four further clocks have seen it deasserted. A bus access is taken only at the seventh or later rising edge at which hw_rst_i is sampled low; earlier writes are ignored.
- R2: During internal reset the outputs take these values: clk_ctl_o = 0x0010 (bypass), lock count = 40, pll_lock_o = 1, soft_rst_o = 0 and bus_rdata_o = 0. Both configuration words hold the boot pins in bits 2:0 and zero elsewhere.
- R3: A write to offset 2 whose bits 2:0 equal 3'b111 drives soft_rst_o high for exactly the cycle after the write edge. Bits 15:3 are ignored, and the values 0 to 6 in bits 2:0 produce no pulse.
- R4: At the clock edge that ends a soft-reset pulse, the active configuration is loaded from the pending configuration. If a direct write to the active configuration arrives on that same edge, the copy wins. cfg_o shows the result one edge later.
- R5: A soft reset changes none of these: the clock-control word, the lock count, the pending configuration, and the lock countdown in progress.
- R6: A register written at edge N appears on its output port (clk_ctl_o, cfg_o) after edge N+1.
- R7: A clock-control write at edge N whose bits 3:0 differ from the held value clears pll_lock_o after edge N. The flag is set again after edge N+L+1, where L is the lock count. A write with an unchanged multiplier leaves the lock state alone.
- R8: The lock count is 10 bits wide; writes keep bits 9:0, and reads return zero in bits 15:10.
- R9: A read of a mapped offset updates bus_rdata_o at its clock edge with the register's value before that edge. Offset 2 reads as zero.
- R10: Accesses whose page differs from the block's page (5) have no effect.
- R11: Changes on the boot pins after internal reset ends do not change either configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| hw_rst_i | input | 1 | Hardware reset, active high, asynchronous to nothing else |
| boot_pins_i | input | 3 | Boot-mode straps |
| bus_page_i | input | 4 | I/O page of the current access |
| bus_addr_i | input | 8 | Address within the page |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| soft_rst_o | output | 1 | Single-cycle software reset pulse |
| cfg_o | output | 16 | Active system configuration |
| clk_ctl_o | output | 16 | Clock-control word |
| pll_lock_o | output | 1 | PLL lock indication |

## Verification
A corrupted active configuration shows on cfg_o one edge after the state goes wrong. A wrong pending word or lock count stays hidden until a soft reset copies it or a read brings it out. For that reason the bench reads those registers back and fires soft resets at chosen points. A countdown that is off by even one cycle shows at the edge where pll_lock_o rises, because every output is compared against a behavioural model on every clock. A reset release that comes early or late shows up as a write accepted or dropped inside the release window.

// File: rtl/rstcfg_pkg.sv
package rstcfg_pkg;
  localparam int NUM_REGS  = 5;
  localparam int OFF_CLK   = 0;
  localparam int OFF_LOCK  = 1;
  localparam int OFF_SRST  = 2;
  localparam int OFF_NEXT  = 3;
  localparam int OFF_ACT   = 4;
  localparam int KEY_W     = 3;
  localparam logic [KEY_W-1:0] SRST_KEY = 3'b111;
endpackage

// File: rtl/rstcfg_rst_cond.sv
module rstcfg_rst_cond #(
  parameter int STAGES = 2,
  parameter int HOLD   = 4
) (
  input  logic clk_i,
  input  logic hw_rst_i,
  output logic rst_o
);
  localparam int CNT_W = $clog2(HOLD + 1);

  logic [STAGES-1:0] sync_q;
  logic [CNT_W-1:0]  run_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i) sync_q[0] <= hw_rst_i;
      end else begin : g_next
        always_ff @(posedge clk_i) sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (sync_q[STAGES-1])          run_q <= '0;
    else if (run_q != CNT_W'(HOLD)) run_q <= run_q + 1'b1;
  end

  assign rst_o = sync_q[STAGES-1] | (run_q != CNT_W'(HOLD));

  // Release only after the raw input has been low for at least two edges
  assert_release_R1: assert property (@(posedge clk_i) disable iff (hw_rst_i)
    $fell(rst_o) |-> (!$past(hw_rst_i) && !$past(hw_rst_i, 2)));
endmodule

// File: rtl/rstcfg_cfg_bank.sv
module rstcfg_cfg_bank #(
  parameter int DATA_W = 16,
  parameter int BOOT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [BOOT_W-1:0] boot_i,
  input  logic              copy_i,
  input  logic              wr_next_i,
  input  logic              wr_act_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] next_o,
  output logic [DATA_W-1:0] act_o,
  output logic [DATA_W-1:0] act_out_o
);
  logic [DATA_W-1:0] strap_word;
  assign strap_word = {{(DATA_W-BOOT_W){1'b0}}, boot_i};

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      next_o    <= strap_word;
      act_o     <= strap_word;
      act_out_o <= strap_word;
    end else begin
      if (wr_next_i) next_o <= wdata_i;
      if (copy_i)        act_o <= next_o;
      else if (wr_act_i) act_o <= wdata_i;
      act_out_o <= act_o;
    end
  end

  assert_copy_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    copy_i |=> (act_o == $past(next_o)));
endmodule

// File: rtl/rstcfg_lock_track.sv
module rstcfg_lock_track #(
  parameter int LOCK_W   = 10,
  parameter int LOCK_RST = 40
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_cnt_i,
  input  logic [LOCK_W-1:0] cnt_wdata_i,
  input  logic              reload_i,
  output logic [LOCK_W-1:0] cnt_o,
  output logic              lock_o
);
  logic [LOCK_W-1:0] down_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_o  <= LOCK_W'(LOCK_RST);
      down_q <= '0;
      lock_o <= 1'b1;
    end else begin
      if (wr_cnt_i) cnt_o <= cnt_wdata_i;
      if (reload_i) begin
        down_q <= cnt_o;
        lock_o <= 1'b0;
      end else if (!lock_o) begin
        if (down_q == '0) lock_o <= 1'b1;
        else              down_q <= down_q - 1'b1;
      end
    end
  end

  assert_relock_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(lock_o) |-> ($past(down_q) == '0));
  assert_drop_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    reload_i |=> !lock_o);
endmodule

// File: rtl/rstcfg_ctrl.sv
module rstcfg_ctrl
  import rstcfg_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int MY_PAGE     = 5,
  parameter int BASE_ADDR   = 8'h40,
  parameter int BOOT_W      = 3,
  parameter int MULT_W      = 4,
  parameter int LOCK_W      = 10,
  parameter int LOCK_RST    = 40,
  parameter int CLK_RST     = 16'h0010,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              hw_rst_i,
  input  logic [BOOT_W-1:0] boot_pins_i,
  input  logic [PAGE_W-1:0] bus_page_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              soft_rst_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic [DATA_W-1:0] clk_ctl_o,
  output logic              pll_lock_o
);
  logic                rst_int;
  logic                page_hit;
  logic [NUM_REGS-1:0] sel;
  logic [NUM_REGS-1:0] wr_sel;
  logic [DATA_W-1:0]   clk_q;
  logic [DATA_W-1:0]   next_cfg;
  logic [DATA_W-1:0]   act_cfg;
  logic [LOCK_W-1:0]   lock_cnt;
  logic                mult_chg;
  logic                srst_q;
  logic [DATA_W-1:0]   rd_val;

  rstcfg_rst_cond #(.STAGES(SYNC_STAGES), .HOLD(HOLD_CYCLES)) u_rst (
    .clk_i(clk_i), .hw_rst_i(hw_rst_i), .rst_o(rst_int));

  assign page_hit = (bus_page_i == PAGE_W'(MY_PAGE));

  genvar k;
  generate
    for (k = 0; k < NUM_REGS; k++) begin : g_dec
      assign sel[k]    = page_hit && (bus_addr_i == ADDR_W'(BASE_ADDR + k));
      assign wr_sel[k] = sel[k] && bus_wr_i;
    end
  endgenerate

  assign mult_chg = wr_sel[OFF_CLK] &&
                    (bus_wdata_i[MULT_W-1:0] != clk_q[MULT_W-1:0]);

  always_ff @(posedge clk_i) begin
    if (rst_int) begin
      clk_q     <= DATA_W'(CLK_RST);
      clk_ctl_o <= DATA_W'(CLK_RST);
      srst_q    <= 1'b0;
    end else begin
      if (wr_sel[OFF_CLK]) clk_q <= bus_wdata_i;
      clk_ctl_o <= clk_q;
      srst_q    <= wr_sel[OFF_SRST] && (bus_wdata_i[KEY_W-1:0] == SRST_KEY);
    end
  end
  assign soft_rst_o = srst_q;

  rstcfg_cfg_bank #(.DATA_W(DATA_W), .BOOT_W(BOOT_W)) u_cfg (
    .clk_i(clk_i), .rst_i(rst_int), .boot_i(boot_pins_i), .copy_i(srst_q),
    .wr_next_i(wr_sel[OFF_NEXT]), .wr_act_i(wr_sel[OFF_ACT]),
    .wdata_i(bus_wdata_i), .next_o(next_cfg), .act_o(act_cfg),
    .act_out_o(cfg_o));

  rstcfg_lock_track #(.LOCK_W(LOCK_W), .LOCK_RST(LOCK_RST)) u_lock (
    .clk_i(clk_i), .rst_i(rst_int), .wr_cnt_i(wr_sel[OFF_LOCK]),
    .cnt_wdata_i(bus_wdata_i[LOCK_W-1:0]), .reload_i(mult_chg),
    .cnt_o(lock_cnt), .lock_o(pll_lock_o));

  always_comb begin
    rd_val = '0;
    if (sel[OFF_CLK])  rd_val = clk_q;
    if (sel[OFF_LOCK]) rd_val = DATA_W'(lock_cnt);
    if (sel[OFF_NEXT]) rd_val = next_cfg;
    if (sel[OFF_ACT])  rd_val = act_cfg;
  end

  always_ff @(posedge clk_i) begin
    if (rst_int)                bus_rdata_o <= '0;
    else if (bus_rd_i && |sel)  bus_rdata_o <= rd_val;
  end

  assert_trigger_R3: assert property (@(posedge clk_i) disable iff (hw_rst_i)
    soft_rst_o |-> ($past(bus_wr_i) && ($past(bus_wdata_i[KEY_W-1:0]) == SRST_KEY)));
  assert_clk_kept_R5: assert property (@(posedge clk_i) disable iff (rst_int)
    (soft_rst_o && !wr_sel[OFF_CLK]) |=> $stable(clk_q));
  assert_lock_in_rst_R2: assert property (@(posedge clk_i) disable iff (hw_rst_i)
    rst_int |=> pll_lock_o);
endmodule

// File: tb/rstcfg_ctrl_test.sv
module rstcfg_ctrl_test;
  localparam int PERIOD = 10;
  localparam int SETTLE = 6;
  localparam logic [3:0] PG = 4'd5;
  localparam int BASE = 8'h40;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic        hw_rst = 1'b1;
  logic [2:0]  boot = 3'b101;
  logic [3:0]  b_page = '0;
  logic [7:0]  b_addr = '0;
  logic        b_wr = 1'b0, b_rd = 1'b0;
  logic [15:0] b_wdata = '0;
  logic [15:0] rdata, cfg, clkc;
  logic        srst, lock;

  rstcfg_ctrl uut (
    .clk_i(clk), .hw_rst_i(hw_rst), .boot_pins_i(boot), .bus_page_i(b_page),
    .bus_addr_i(b_addr), .bus_wr_i(b_wr), .bus_rd_i(b_rd), .bus_wdata_i(b_wdata),
    .bus_rdata_o(rdata), .soft_rst_o(srst), .cfg_o(cfg), .clk_ctl_o(clkc),
    .pll_lock_o(lock));

  int nvec = 0, nfail = 0;
  bit cmp_on = 0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int low_run = 0;
  logic [15:0] m_clk, m_lcnt, m_next, m_act, m_clko, m_cfgo, m_rdata;
  int m_down;
  logic m_lock, m_srst;
  int ofs;
  bit hit, mapped, w;

  function automatic logic [15:0] rdval(input int o);
    case (o)
      0: return m_clk;
      1: return m_lcnt;
      3: return m_next;
      4: return m_act;
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    hit = (b_page == PG);
    ofs = int'(b_addr) - BASE;
    mapped = hit && ofs >= 0 && ofs < 5;
    w = b_wr && mapped;
    if (low_run < SETTLE) begin
      m_clk = 16'h0010; m_clko = 16'h0010; m_lcnt = 16'd40; m_down = 0;
      m_lock = 1'b1; m_next = {13'b0, boot}; m_act = {13'b0, boot};
      m_cfgo = {13'b0, boot}; m_srst = 1'b0; m_rdata = 16'h0;
    end else begin
      if (b_rd && mapped) m_rdata = rdval(ofs);
      m_clko = m_clk;
      m_cfgo = m_act;
      if (w && ofs == 0 && b_wdata[3:0] != m_clk[3:0]) begin
        m_down = int'(m_lcnt); m_lock = 1'b0;
      end else if (!m_lock) begin
        if (m_down == 0) m_lock = 1'b1; else m_down--;
      end
      if (m_srst) m_act = m_next;
      else if (w && ofs == 4) m_act = b_wdata;
      if (w && ofs == 3) m_next = b_wdata;
      if (w && ofs == 1) m_lcnt = b_wdata & 16'h03FF;
      if (w && ofs == 0) m_clk = b_wdata;
      m_srst = w && ofs == 2 && b_wdata[2:0] == 3'b111;
    end
    if (hw_rst) low_run = 0;
    else if (low_run < SETTLE) low_run++;
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R3 soft_rst_o vs model", {15'b0, srst}, {15'b0, m_srst});
      chk("R4 cfg_o vs model", cfg, m_cfgo);
      chk("R6 clk_ctl_o vs model", clkc, m_clko);
      chk("R7 pll_lock_o vs model", {15'b0, lock}, {15'b0, m_lock});
      chk("R9 bus_rdata_o vs model", rdata, m_rdata);
    end
  end

  task automatic wr(input logic [3:0] pg, input int o, input logic [15:0] d);
    @(negedge clk);
    b_page = pg; b_addr = 8'(BASE + o); b_wdata = d; b_wr = 1'b1;
    @(negedge clk);
    b_wr = 1'b0;
  endtask

  task automatic rd(input int o);
    @(negedge clk);
    b_page = PG; b_addr = 8'(BASE + o); b_rd = 1'b1;
    @(negedge clk);
    b_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog expired (all requirements)");
    finish_run();
  end

  initial begin
    idle(2);
    cmp_on = 1;
    idle(6);
    chk("R2 clk_ctl_o reset", clkc, 16'h0010);
    chk("R2 lock in reset", {15'b0, lock}, 16'h1);
    @(negedge clk); hw_rst = 1'b0;
    wr(PG, 3, 16'h7777);              // R1: inside release window, dropped
    wr(PG, 0, 16'h00FF);              // R1: dropped
    idle(8);
    boot = 3'b010;                    // R11: too late to be captured
    idle(3);
    chk("R1 clk write in window ignored", clkc, 16'h0010);
    chk("R11 cfg_o keeps strapped boot", cfg, 16'h0005);
    rd(3);
    chk("R1 pending cfg write in window ignored", rdata, 16'h0005);
    rd(1);
    chk("R2 lock count reset value", rdata, 16'd40);
    wr(PG, 1, 16'hFFFF);
    rd(1);
    chk("R8 lock count 10 bits", rdata, 16'h03FF);
    wr(PG, 1, 16'd12);
    wr(PG, 0, 16'h0013);
    chk("R7 lock drops after multiplier change", {15'b0, lock}, 16'h0);
    idle(1);
    chk("R6 clk_ctl_o after second edge", clkc, 16'h0013);
    idle(20);
    chk("R7 lock back after countdown", {15'b0, lock}, 16'h1);
    wr(PG, 0, 16'h0083);
    idle(2);
    chk("R7 same multiplier keeps lock", {15'b0, lock}, 16'h1);
    wr(PG, 3, 16'hA5A0);
    wr(PG, 2, 16'h0006);
    chk("R3 value 6 gives no pulse", {15'b0, srst}, 16'h0);
    idle(2);
    chk("R3 no copy without pulse", cfg, 16'h0005);
    wr(PG, 2, 16'hFFF7);
    chk("R3 pulse on key with upper bits set", {15'b0, srst}, 16'h1);
    idle(1);
    chk("R3 pulse lasts one cycle", {15'b0, srst}, 16'h0);
    idle(1);
    chk("R4 active takes pending on soft reset", cfg, 16'hA5A0);
    chk("R5 clk_ctl_o unchanged by soft reset", clkc, 16'h0083);
    rd(3);
    chk("R5 pending cfg unchanged by soft reset", rdata, 16'hA5A0);
    rd(2);
    chk("R9 trigger offset reads zero", rdata, 16'h0000);
    wr(PG, 0, 16'h0015);
    wr(PG, 2, 16'h0007);
    idle(3);
    chk("R5 countdown continues through soft reset", {15'b0, lock}, 16'h0);
    idle(15);
    chk("R5 lock returns on schedule", {15'b0, lock}, 16'h1);
    wr(4'd4, 0, 16'h0000);
    wr(4'd4, 2, 16'h0007);
    chk("R10 other page no pulse", {15'b0, srst}, 16'h0);
    idle(2);
    chk("R10 other page write ignored", clkc, 16'h0015);
    wr(PG, 4, 16'h1234);
    idle(1);
    chk("R6 direct active write visible", cfg, 16'h1234);
    wr(PG, 3, 16'h0F0F);
    wr(PG, 2, 16'h0007);
    b_page = PG; b_addr = 8'(BASE + 4); b_wdata = 16'hBEEF; b_wr = 1'b1;
    @(negedge clk); b_wr = 1'b0;
    idle(1);
    chk("R4 copy wins over same-edge write", cfg, 16'h0F0F);
    idle(4);
    finish_run();
  end
endmodule